// File: doc/BRIEF.md
# Page Write Staging and Commit Timer

This block sits behind the byte-level engine of a serial memory slave. It collects the data bytes of one write transaction in a row-sized latch and writes nothing to the memory array until the transaction ends with a Stop in the slot right after an acknowledge. A Stop anywhere else throws the staged bytes away.

A qualifying commit starts a self-timed write cycle of a fixed number of system clocks. During that cycle the block raises `busy_o`, and the slave engine must stay off the bus. The block drops every strobe it receives during the cycle. The latched entries go to the array one per clock at the start of the cycle.

The start address splits in two. Its upper bits select the row. Its low bits select the first latch entry. Only the low bits advance from byte to byte, so a long burst wraps inside the row and overwrites entries it has already filled. A single-byte write is simply a page write that carries one byte.

Top module: `page_commit_unit`

## Requirements
- R1: On `addr_load_i`, the upper `ADDR_W-5` bits of `addr_i` become the row and the low 5 bits become the entry pointer. Every array write of the following commit carries that row in `arr_addr_o[ADDR_W-1:5]`.
- R2: Each byte strobe moves the pointer up by one, modulo 32. When the pointer passes entry 31 it goes back to entry 0 of the same row. The last byte latched into an entry is the one written.
- R3: A byte strobe with `byte_wen_i` low latches nothing, but it still moves the pointer on. Such an entry is never written.
- R4: A Stop with `stop_slot_i` equal to 10 (the slot right after an ACK), when at least one entry is latched, starts a write cycle. `busy_o` is high at the first sample after the clock edge that captured the Stop.
- R5: A Stop with any other slot value clears every latched entry and does not start a write cycle. A later Stop in slot 10 with no new bytes also starts none.
- R6: A Stop in slot 10 with no latched entry starts no write cycle.
- R7: `busy_o` stays high for exactly `WCYC` clock cycles. During the write cycle, `arr_we_o` pulses once for each latched entry and for no other entry. The pulses come in ascending entry order, and each carries that entry's latched byte on `arr_data_o`.
- R8: While `busy_o` is high, address loads, byte strobes and Stop strobes have no effect. The cycle length does not change, the data written does not change, and nothing stays latched once the cycle ends.
- R9: After reset, `busy_o` and `arr_we_o` are low and no entry is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Start address valid strobe |
| addr_i | input | ADDR_W | Start address (row and entry) |
| byte_stb_i | input | 1 | Data byte received strobe |
| byte_wen_i | input | 1 | Byte may be written (write control low) |
| byte_data_i | input | DATA_W | Received data byte |
| stop_stb_i | input | 1 | Stop condition seen |
| stop_slot_i | input | 4 | Bit slot of the Stop; 10 means right after an ACK |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The bench drives transactions of several shapes and compares them with a reference model of the latch:
- a single byte, which checks that a byte write needs no special path;
- a full 32-byte row, which checks ascending order and full coverage;
- a burst that starts at entry 30, which separates in-row wrap from a carry into the row bits;
- a 34-byte burst, which shows whether later bytes overwrite earlier ones;
- a burst at the top address, which checks that the row bits do not roll over.

Further transactions cover the other inputs:
- Stops in a wrong slot and transactions with zero data bytes tell commit qualification apart from plain Stop detection.
- Bytes sent with writing disabled, and a mix of enabled and disabled bytes, show that the pointer advances for disabled bytes although nothing is latched.
- Traffic sent in the middle of a write cycle shows whether the busy window truly ignores the bus.

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WCYC       = 200,
  parameter int SLOT_W     = 4,
  parameter int STOP_SLOT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_stb_i,
  input  logic              byte_wen_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_stb_i,
  input  logic [SLOT_W-1:0] stop_slot_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(WCYC + 1);

  logic [ROW_W-1:0]      row_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]     dat_q [PAGE_BYTES];
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;

  wire              commit  = stop_stb_i && (stop_slot_i == SLOT_W'(STOP_SLOT)) && (|vld_q);
  wire              in_scan = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  wire [OFS_W-1:0]  idx     = cnt_q[OFS_W-1:0];
  wire              last    = (cnt_q == CNT_W'(WCYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= '0;
      row_q  <= '0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (last) begin
        busy_q <= 1'b0;
        vld_q  <= '0;
      end
    end else if (addr_load_i) begin
      row_q <= addr_i[ADDR_W-1:OFS_W];
      ptr_q <= addr_i[OFS_W-1:0];
      vld_q <= '0;
    end else if (byte_stb_i) begin
      if (byte_wen_i) vld_q[ptr_q] <= 1'b1;
      ptr_q <= ptr_q + OFS_W'(1);
    end else if (stop_stb_i) begin
      if (commit) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        vld_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy_q && !addr_load_i && byte_stb_i && byte_wen_i)
      dat_q[ptr_q] <= byte_data_i;
  end

  assign arr_we_o   = in_scan && vld_q[idx];
  assign arr_addr_o = {row_q, idx};
  assign arr_data_o = dat_q[idx];
  assign busy_o     = busy_q;
endmodule

// File: rtl/page_commit_unit_chk.sv
module page_commit_unit_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int WCYC       = 200,
  parameter int SLOT_W     = 4,
  parameter int STOP_SLOT  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              stop_stb_i,
  input logic [SLOT_W-1:0] stop_slot_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  logic [31:0]              run_q;
  logic [ADDR_W-1:OFS_W]    row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      row_q <= '0;
    end else begin
      run_q <= busy_o ? run_q + 32'd1 : 32'd0;
      if (addr_load_i && !busy_o) row_q <= addr_i[ADDR_W-1:OFS_W];
    end
  end

  AST_WE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (arr_addr_o[ADDR_W-1:OFS_W] == row_q)); // R1
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_stb_i) && $past(stop_slot_i) == SLOT_W'(STOP_SLOT))); // R4
  AST_BAD_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && stop_stb_i && !addr_load_i && stop_slot_i != SLOT_W'(STOP_SLOT)) |=> !busy_o); // R5
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == 32'(WCYC))); // R7
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R7
endmodule

bind page_commit_unit page_commit_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WCYC(WCYC),
  .SLOT_W(SLOT_W), .STOP_SLOT(STOP_SLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
  .stop_stb_i(stop_stb_i), .stop_slot_i(stop_slot_i), .arr_we_o(arr_we_o),
  .arr_addr_o(arr_addr_o), .busy_o(busy_o)
);

// File: tb/page_commit_unit_bench.sv
module page_commit_unit_bench;
  localparam int CLK_P = 10;
  localparam int WCYC  = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_load_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic        byte_stb_i = 1'b0;
  logic        byte_wen_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        stop_stb_i = 1'b0;
  logic [3:0]  stop_slot_i = '0;
  logic        arr_we_o;
  logic [12:0] arr_addr_o;
  logic [7:0]  arr_data_o;
  logic        busy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  page_commit_unit #(.WCYC(WCYC)) u_page_commit_unit (
    .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .byte_stb_i(byte_stb_i), .byte_wen_i(byte_wen_i), .byte_data_i(byte_data_i),
    .stop_stb_i(stop_stb_i), .stop_slot_i(stop_slot_i), .arr_we_o(arr_we_o),
    .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o), .busy_o(busy_o)
  );

  // {addr[12:0], nbytes[5:0], data0[7:0], wen, slot[3:0]}
  localparam logic [31:0] VEC [8] = '{
    {13'h0040, 6'd1,  8'hA5, 1'b1, 4'd10},
    {13'h0100, 6'd32, 8'h10, 1'b1, 4'd10},
    {13'h0ABE, 6'd4,  8'h20, 1'b1, 4'd10},
    {13'h1F05, 6'd34, 8'h40, 1'b1, 4'd10},
    {13'h0200, 6'd3,  8'h60, 1'b1, 4'd7},
    {13'h0300, 6'd0,  8'h00, 1'b1, 4'd10},
    {13'h0400, 6'd3,  8'h70, 1'b0, 4'd10},
    {13'h1FFF, 6'd2,  8'h80, 1'b1, 4'd10}
  };

  logic [31:0] ref_vld;
  logic [7:0]  ref_dat [32];
  logic [7:0]  ref_row;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_txn(input logic [12:0] a, input int n, input logic [7:0] d0,
                          input logic [63:0] mask, input logic [3:0] slot);
    logic [4:0] p;
    ref_vld = '0;
    ref_row = a[12:5];
    p = a[4:0];
    addr_load_i = 1'b1; addr_i = a;
    @(negedge clk);
    addr_load_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_stb_i = 1'b1; byte_wen_i = mask[i]; byte_data_i = d0 + 8'(i);
      if (mask[i]) begin ref_dat[p] = d0 + 8'(i); ref_vld[p] = 1'b1; end
      p = p + 5'd1;
      @(negedge clk);
    end
    byte_stb_i = 1'b0; byte_wen_i = 1'b0;
    stop_stb_i = 1'b1; stop_slot_i = slot;
    @(negedge clk);
    stop_stb_i = 1'b0;
  endtask

  // observes the write cycle; optionally injects traffic during it (R8)
  task automatic observe(input bit exp_commit, input bit inject, input string tag);
    int bcnt = 0;
    int wcnt = 0;
    int prev = -1;
    logic [31:0] seen = '0;
    chk(busy_o == exp_commit, {tag, " R4 busy after stop"}, busy_o, exp_commit);
    while (busy_o && bcnt < 2000) begin
      if (arr_we_o) begin
        int ix = int'(arr_addr_o[4:0]);
        chk(arr_addr_o[12:5] == ref_row, {tag, " R1 row"}, arr_addr_o[12:5], ref_row);
        chk(ref_vld[ix] && arr_data_o == ref_dat[ix], {tag, " R7 data"}, arr_data_o, ref_dat[ix]);
        chk(ix > prev, {tag, " R7 order"}, ix, prev + 1);
        prev = ix;
        seen[ix] = 1'b1;
        wcnt++;
      end
      if (inject) begin
        addr_load_i = (bcnt == 3); addr_i = 13'h0777;
        byte_stb_i = (bcnt > 5 && bcnt < 40); byte_wen_i = 1'b1; byte_data_i = 8'hEE;
        stop_stb_i = (bcnt == 50); stop_slot_i = 4'd10;
      end
      bcnt++;
      @(negedge clk);
    end
    addr_load_i = 1'b0; byte_stb_i = 1'b0; stop_stb_i = 1'b0;
    chk(bcnt == (exp_commit ? WCYC : 0), {tag, " R7 busy length"}, bcnt, exp_commit ? WCYC : 0);
    chk(wcnt == $countones(ref_vld) || !exp_commit, {tag, " R7 write count"}, wcnt, $countones(ref_vld));
    chk(seen == (exp_commit ? ref_vld : 32'd0), {tag, " R2 entries written"}, seen, ref_vld);
    chk(!arr_we_o, {tag, " R7 no write when idle"}, arr_we_o, 0);
  endtask

  task automatic bare_stop(input string tag);
    stop_stb_i = 1'b1; stop_slot_i = 4'd10;
    @(negedge clk);
    stop_stb_i = 1'b0;
    chk(!busy_o, {tag}, busy_o, 0);
    @(negedge clk);
    chk(!busy_o && !arr_we_o, {tag}, busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R9 busy after reset", busy_o, 0);
    chk(!arr_we_o, "R9 write strobe after reset", arr_we_o, 0);
    bare_stop("R9 empty latch after reset");

    for (int v = 0; v < 8; v++) begin
      logic [31:0] e = VEC[v];
      logic [63:0] m = e[4] ? '1 : '0;
      bit ec;
      send_txn(e[31:19], int'(e[18:13]), e[12:5], m, e[3:0]);
      ec = (e[3:0] == 4'd10) && (ref_vld != 0);
      observe(ec, 1'b0, $sformatf("vec%0d R6 R3", v));
      if (v == 4) bare_stop("R5 stop after discard");
    end

    // R3 mixed enable: entries 0 and 2 written, entry 1 skipped
    send_txn(13'h0600, 3, 8'h90, 64'b101, 4'd10);
    chk(ref_vld == 32'b101, "R3 model mask", ref_vld, 32'b101);
    observe(1'b1, 1'b0, "R3 mixed");

    // R8 traffic during write cycle is ignored
    send_txn(13'h0820, 2, 8'hC0, '1, 4'd10);
    observe(1'b1, 1'b1, "R8 inject");
    bare_stop("R8 nothing latched after busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule